// File: doc/BRIEF.md
# Two-Stage Top-Two Track Selector

This block takes one track candidate from each sub-sector cluster of a trigger sector and, every clock cycle, reports the two candidates with the highest momentum level. A candidate carries a 3-bit momentum level, a charge bit and a 3-bit sub-sector index; its cluster index is its position on the input bus. The number of clusters is a parameter (23 for a large sector, 8 for a small one).

The search runs in two stages. In the first stage, six pre-selectors work in parallel, one per momentum level. Each pre-selector gathers the candidates of its own level and keeps the two with the lowest cluster index. The lowest cluster index stands for the lowest pseudorapidity. In the second stage, the twelve survivors are merged, and the two best by level are chosen, with ties going to the lower cluster index. Registers sit on the input, after the pre-select stage and after the final stage. The block accepts a new set of inputs on every cycle, and an input valid bit travels down the pipeline with the data.

Top module: `trksel_top`

## Requirements
- R1: The result for the inputs sampled at one rising edge appears on the outputs right after the third rising edge counted from that one, and a new input set is accepted on every cycle with no gap.
- R2: Each valid output slot reports the level, charge and sub-sector index that were presented at the cluster position it names.
- R3: Among candidates of equal level, the one at the lower cluster index ranks ahead.
- R4: Slot 0 holds the first candidate and slot 1 the second candidate in the order of level descending, then cluster index ascending.
- R5: An input whose level code is 0 or 7 is ignored; only codes 1 to 6 are tracks.
- R6: If fewer than two tracks are present, each unused slot has its valid bit low and all of its fields zero. Slot 1 is never valid while slot 0 is invalid.
- R7: `out_vld` repeats `in_vld` three cycles later. When `in_vld` was low, both slots are invalid whatever the levels were.
- R8: While reset is asserted, every output is zero.
- R9: When more than two tracks share the top level, the two with the lowest cluster indices are reported and all others are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input set valid |
| in_lvl | input | N_CLU*3 | Level per cluster; cluster c uses bits [3c+2:3c] |
| in_chg | input | N_CLU | Charge per cluster |
| in_sub | input | N_CLU*3 | Sub-sector index per cluster; cluster c uses bits [3c+2:3c] |
| out_vld | output | 1 | Delayed input valid |
| o0_vld | output | 1 | Slot 0 holds a track |
| o0_lvl | output | 3 | Slot 0 level |
| o0_chg | output | 1 | Slot 0 charge |
| o0_clu | output | 5 | Slot 0 cluster index |
| o0_sub | output | 3 | Slot 0 sub-sector index |
| o1_vld | output | 1 | Slot 1 holds a track |
| o1_lvl | output | 3 | Slot 1 level |
| o1_chg | output | 1 | Slot 1 charge |
| o1_clu | output | 5 | Slot 1 cluster index |
| o1_sub | output | 3 | Slot 1 sub-sector index |

## Verification
The assertions assume that `N_CLU` fits the 5-bit cluster field. They also assume that the input bus carries one candidate per cluster, so no two candidates share a cluster index and the ordering inside a level is strict. The bench builds every input set from a per-cluster array, so this property holds by construction. The bench sweeps every pair of level codes, including the ignored codes, over every ordered pair of distinct clusters. It then streams random back-to-back sets in which the input valid bit is sometimes low.

// File: rtl/trksel_pkg.sv
package trksel_pkg;
  localparam int LVL_W = 3;
  localparam int SUB_W = 3;
  localparam int CLU_W = 5;
  localparam int N_LVL = 6;
  localparam int N_KEEP = 2;
  localparam int N_CAND = N_LVL * N_KEEP;

  typedef struct packed {
    logic             vld;
    logic [LVL_W-1:0] lvl;
    logic             chg;
    logic [CLU_W-1:0] clu;
    logic [SUB_W-1:0] sub;
  } trk_t;

  localparam trk_t TRK_NONE = '0;

  // A level code counts as a track only inside 1..N_LVL.
  function automatic logic lvl_live(input logic [LVL_W-1:0] l);
    return (l != '0) && (l <= LVL_W'(N_LVL));
  endfunction

  // True when a ranks strictly ahead of b: higher level, then lower cluster.
  function automatic logic ranks_ahead(input trk_t a, input trk_t b);
    if (!a.vld) return 1'b0;
    if (!b.vld) return 1'b1;
    if (a.lvl != b.lvl) return a.lvl > b.lvl;
    return a.clu < b.clu;
  endfunction
endpackage

// File: rtl/trksel_in_reg.sv
module trksel_in_reg
  import trksel_pkg::*;
#(
  parameter int N_CLU = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [N_CLU*LVL_W-1:0] in_lvl,
  input  logic [N_CLU-1:0]       in_chg,
  input  logic [N_CLU*SUB_W-1:0] in_sub,
  output trk_t                   cand [N_CLU],
  output logic                   cand_set_vld
);
  for (genvar c = 0; c < N_CLU; c++) begin : g_clu
    logic [LVL_W-1:0] lvl_c;
    logic             live_c;
    assign lvl_c  = in_lvl[c*LVL_W +: LVL_W];
    assign live_c = in_vld && lvl_live(lvl_c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cand[c] <= TRK_NONE;
      end else begin
        cand[c].vld <= live_c;
        cand[c].lvl <= live_c ? lvl_c : '0;
        cand[c].chg <= live_c ? in_chg[c] : 1'b0;
        cand[c].clu <= CLU_W'(c);
        cand[c].sub <= live_c ? in_sub[c*SUB_W +: SUB_W] : '0;
      end
    end

    AST_CAND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cand[c].vld |-> lvl_live(cand[c].lvl)); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_set_vld <= 1'b0;
    else        cand_set_vld <= in_vld;
  end
endmodule

// File: rtl/trksel_pre.sv
module trksel_pre
  import trksel_pkg::*;
#(
  parameter int N_CLU = 23,
  parameter int LEVEL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  trk_t cand [N_CLU],
  output trk_t keep0,
  output trk_t keep1
);
  trk_t pick0, pick1;

  // Walk from the top cluster down; each match pushes the earlier pick back,
  // leaving the lowest index in pick0 and the next lowest in pick1.
  always_comb begin
    pick0 = TRK_NONE;
    pick1 = TRK_NONE;
    for (int i = N_CLU - 1; i >= 0; i--) begin
      if (cand[i].vld && cand[i].lvl == LVL_W'(LEVEL)) begin
        pick1 = pick0;
        pick0 = cand[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep0 <= TRK_NONE;
      keep1 <= TRK_NONE;
    end else begin
      keep0 <= pick0;
      keep1 <= pick1;
    end
  end

  AST_PRE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    keep0.vld |-> keep0.lvl == LVL_W'(LEVEL)); // R2
  AST_PRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    keep1.vld |-> keep0.vld && keep0.clu < keep1.clu); // R3
endmodule

// File: rtl/trksel_final.sv
module trksel_final
  import trksel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_vld,
  input  trk_t pre [N_CAND],
  output trk_t slot0,
  output trk_t slot1
);
  trk_t best0, best1;

  // Candidates enter from the lowest level upward, and within a level the
  // second keeper before the first, so the last two pushes are the winners.
  always_comb begin
    best0 = TRK_NONE;
    best1 = TRK_NONE;
    for (int l = 0; l < N_LVL; l++) begin
      for (int k = N_KEEP - 1; k >= 0; k--) begin
        if (set_vld && pre[l*N_KEEP + k].vld) begin
          best1 = best0;
          best0 = pre[l*N_KEEP + k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= TRK_NONE;
      slot1 <= TRK_NONE;
    end else begin
      slot0 <= best0;
      slot1 <= best1;
    end
  end

  AST_OUT_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    slot1.vld |-> ranks_ahead(slot0, slot1)); // R4
  AST_OUT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !slot0.vld |-> slot1 == TRK_NONE); // R6
  AST_OUT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    slot0.vld |-> lvl_live(slot0.lvl)); // R5
endmodule

// File: rtl/trksel_top.sv
module trksel_top
  import trksel_pkg::*;
#(
  parameter int N_CLU = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [N_CLU*LVL_W-1:0] in_lvl,
  input  logic [N_CLU-1:0]       in_chg,
  input  logic [N_CLU*SUB_W-1:0] in_sub,
  output logic                   out_vld,
  output logic                   o0_vld,
  output logic [LVL_W-1:0]       o0_lvl,
  output logic                   o0_chg,
  output logic [CLU_W-1:0]       o0_clu,
  output logic [SUB_W-1:0]       o0_sub,
  output logic                   o1_vld,
  output logic [LVL_W-1:0]       o1_lvl,
  output logic                   o1_chg,
  output logic [CLU_W-1:0]       o1_clu,
  output logic [SUB_W-1:0]       o1_sub
);
  trk_t cand [N_CLU];
  trk_t pre_keep [N_CAND];
  trk_t slot0, slot1;
  logic s1_vld, s2_vld, s3_vld;
  logic pre_any;

  trksel_in_reg #(.N_CLU(N_CLU)) u_in (
    .clk, .rst_n, .in_vld, .in_lvl, .in_chg, .in_sub,
    .cand(cand), .cand_set_vld(s1_vld)
  );

  for (genvar g = 0; g < N_LVL; g++) begin : g_pre
    trksel_pre #(.N_CLU(N_CLU), .LEVEL(g + 1)) u_pre (
      .clk, .rst_n, .cand(cand),
      .keep0(pre_keep[g*N_KEEP]), .keep1(pre_keep[g*N_KEEP + 1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
    end
  end

  trksel_final u_fin (
    .clk, .rst_n, .set_vld(s2_vld), .pre(pre_keep),
    .slot0(slot0), .slot1(slot1)
  );

  always_comb begin
    pre_any = 1'b0;
    for (int j = 0; j < N_CAND; j++) pre_any = pre_any | pre_keep[j].vld;
  end

  assign out_vld = s3_vld;
  assign o0_vld  = slot0.vld;
  assign o0_lvl  = slot0.lvl;
  assign o0_chg  = slot0.chg;
  assign o0_clu  = slot0.clu;
  assign o0_sub  = slot0.sub;
  assign o1_vld  = slot1.vld;
  assign o1_lvl  = slot1.lvl;
  assign o1_chg  = slot1.chg;
  assign o1_clu  = slot1.clu;
  assign o1_sub  = slot1.sub;

  AST_VLD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |=> out_vld); // R7
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld |=> !out_vld && !o0_vld); // R7
  AST_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && pre_any) |=> o0_vld); // R1
  AST_CLU_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    o0_vld |-> int'(o0_clu) < N_CLU); // R2
endmodule

// File: tb/test_trksel_top.sv
module test_trksel_top;
  localparam int N = 8;
  localparam int W = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [N*3-1:0] in_lvl = '0;
  logic [N-1:0]   in_chg = '0;
  logic [N*3-1:0] in_sub = '0;
  logic out_vld, o0_vld, o0_chg, o1_vld, o1_chg;
  logic [2:0] o0_lvl, o0_sub, o1_lvl, o1_sub;
  logic [4:0] o0_clu, o1_clu;

  int checks = 0;
  int errors = 0;
  int lv [N];
  bit ch [N];
  int sb [N];
  logic [W-1:0] e0 = '0, e1 = '0, e2 = '0;
  string t0 = "R8", t1 = "R8", t2 = "R8";

  always #10 clk = ~clk;

  trksel_top #(.N_CLU(N)) i_trksel_top (
    .clk, .rst_n, .in_vld, .in_lvl, .in_chg, .in_sub,
    .out_vld, .o0_vld, .o0_lvl, .o0_chg, .o0_clu, .o0_sub,
    .o1_vld, .o1_lvl, .o1_chg, .o1_clu, .o1_sub
  );

  function automatic logic [W-1:0] actual();
    return {out_vld, o0_vld, o0_lvl, o0_chg, o0_clu, o0_sub,
            o1_vld, o1_lvl, o1_chg, o1_clu, o1_sub};
  endfunction

  // Reference: scan levels 6 down to 1, clusters upward, take the first two.
  function automatic logic [W-1:0] model(input bit v);
    logic [12:0] s [2];
    int found = 0;
    s[0] = '0;
    s[1] = '0;
    for (int l = 6; l >= 1; l--)
      for (int c = 0; c < N; c++)
        if (v && lv[c] == l && found < 2) begin
          s[found] = {1'b1, 3'(l), ch[c], 5'(c), 3'(sb[c])};
          found++;
        end
    return {v, s[0], s[1]};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp_v);
    checks++;
    if (actual() !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp_v);
    end
  endtask

  task automatic step(input string tag, input bit v);
    @(negedge clk);
    check(t2, e2);
    e2 = e1; t2 = t1;
    e1 = e0; t1 = t0;
    for (int c = 0; c < N; c++) begin
      ch[c] = 1'($urandom_range(0, 1));
      sb[c] = $urandom_range(0, 7);
    end
    e0 = model(v); t0 = tag;
    in_vld = v;
    for (int c = 0; c < N; c++) begin
      in_lvl[c*3 +: 3] = 3'(lv[c]);
      in_chg[c]        = ch[c];
      in_sub[c*3 +: 3] = 3'(sb[c]);
    end
  endtask

  task automatic clear_lv();
    for (int c = 0; c < N; c++) lv[c] = 0;
  endtask

  task automatic run_all();
    // R8: outputs stay zero during reset even with live inputs
    in_vld = 1'b1;
    in_lvl = {N{3'd4}};
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8", '0);
    in_vld = 1'b0;
    in_lvl = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R5: only ignored codes 0 and 7 present
    clear_lv(); lv[1] = 7; lv[5] = 7;
    step("R5", 1'b1);
    // R9: every cluster at the same level
    for (int c = 0; c < N; c++) lv[c] = 3;
    step("R9", 1'b1);
    // R3: equal level, higher index listed first in bus order
    clear_lv(); lv[6] = 5; lv[2] = 5;
    step("R3", 1'b1);
    // R6: a single track, slot 1 stays empty
    clear_lv(); lv[4] = 2;
    step("R6", 1'b1);
    // R7: tracks present but input valid low
    for (int c = 0; c < N; c++) lv[c] = 6;
    step("R7", 1'b0);
    // R4: every pair of level codes over every ordered pair of clusters
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (i != j) begin
              clear_lv(); lv[i] = a; lv[j] = b;
              step("R4", 1'b1);
            end
    // R1 / R2: random back-to-back sets, valid mostly high
    for (int n = 0; n < 2000; n++) begin
      for (int c = 0; c < N; c++)
        lv[c] = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 7);
      step((n % 2 == 0) ? "R1" : "R2", $urandom_range(0, 7) != 0);
    end
    clear_lv();
    repeat (3) step("R7", 1'b0);
    @(negedge clk);
    check(t2, e2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule